// File: doc/BRIEF.md
# Tri-State Phase-Frequency Detector

This block compares two divided clocks inside a frequency synthesizer loop. Each clock arrives as a one-cycle strobe in the system clock domain: `ref_stb` for the divided reference and `fb_stb` for the divided feedback. From which strobe arrives first, and by how many cycles, it forms a loop-error signal in two forms. The first is a single three-state error output, given as a drive value plus an output enable, for a loop filter that integrates charge. The second is a pair of active-low pump pulses for a filter that combines them outside the block.

The core is a four-state machine with the states IDLE, UP, DN and CLR. These are the classic pair of "reference seen" and "feedback seen" flags.

- **IDLE** goes to UP on a lone reference strobe, to DN on a lone feedback strobe, and to CLR when both strobes arrive in the same cycle.
- **UP** goes to CLR when a feedback strobe arrives, and otherwise holds.
- **DN** goes to CLR when a reference strobe arrives, and otherwise holds.
- **CLR** always lasts one cycle. It then follows the IDLE rules, so a strobe that arrives during the clear cycle begins the next comparison.

A lock monitor counts completed comparisons. A comparison counts as clean when no single-sided pulse lasted longer than one cycle. When enough clean comparisons have been counted, the monitor raises `locked`.

Top module: `pfd_tristate`

## Requirements
- R1: While `rst_n` is low, the block holds state IDLE. In that state `err_oe` is 0, `pump_up_n` and `pump_dn_n` are both 1, and `locked` is 0.
- R2: A reference strobe with no feedback strobe, seen in IDLE, moves the block to UP. From the next cycle on, `err_oe`=1 and `err_drive`=1 (drive high: feedback is slow or lagging).
- R3: A feedback strobe with no reference strobe, seen in IDLE, moves the block to DN. From the next cycle on, `err_oe`=1 and `err_drive`=0 (drive low: feedback is fast or leading).
- R4: The opposite strobe, seen in UP or DN, moves the block to CLR. In CLR both pump outputs are 0, `err_oe` is 0, and the state lasts exactly one cycle unless both strobes arrive during it.
- R5: Strobes that coincide in IDLE produce only the CLR cycle. The single-ended output stays at high impedance (`err_oe`=0) throughout.
- R6: `pump_up_n` is 0 exactly in UP and CLR, and `pump_dn_n` is 0 exactly in DN and CLR. A lead of d cycles therefore gives an error pulse of exactly d cycles.
- R7: A repeated strobe of the same side while its pulse is pending is ignored. The pulse neither restarts nor changes polarity.
- R8: Strobes seen in CLR are treated as seen in IDLE, so no edge is lost in the clear cycle.
- R9: Each CLR cycle that follows no pulse wider than one cycle counts one clean comparison. The count saturates at its maximum. `locked` is 1 when the count is nonzero and at least `lock_thresh`.
- R10: A UP or DN state that lasts into its second cycle clears the count. `locked` therefore reads 0 from the following cycle. A one-cycle pulse does not clear the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_stb | input | 1 | One-cycle strobe of the divided reference |
| fb_stb | input | 1 | One-cycle strobe of the divided feedback |
| lock_thresh | input | LOCK_W | Clean comparisons needed for lock |
| err_drive | output | 1 | Level driven on the error output when enabled |
| err_oe | output | 1 | Enable of the error output (0 = high impedance) |
| pump_up_n | output | 1 | Active-low pulse while the reference leads |
| pump_dn_n | output | 1 | Active-low pulse while the feedback leads |
| locked | output | 1 | Lock indication |

## Verification
The bench covers the following corner cases:

- **Coincident strobes.** A design that let them through as a one-cycle single-sided pulse would drive `err_oe` when it should stay at high impedance.
- **Strobes landing in the clear cycle.** A design that gave the reset priority would lose them and stay IDLE.
- **Repeated same-side strobes.** A design that toggled or re-armed on them would stretch or flip the pulse.
- **Exact pulse widths for several leads.** An off-by-one in the flag timing shows up in these widths.
- **The one-cycle versus two-cycle boundary of the lock monitor.** A monitor that tolerated too much, or too little, would hold or drop `locked` on the wrong comparison.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    // Encoding: bit 0 = reference pending, bit 1 = feedback pending
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_UP   = 2'b01,
        ST_DN   = 2'b10,
        ST_CLR  = 2'b11
    } pfd_state_e;

endpackage

// File: rtl/pfd_fsm.sv
module pfd_fsm
    import pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_stb,
    input  logic       fb_stb,
    output pfd_state_e state_q
);

    pfd_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_CLR: begin
                // CLR accepts new strobes just like IDLE
                if (ref_stb && fb_stb) state_d = ST_CLR;
                else if (ref_stb)      state_d = ST_UP;
                else if (fb_stb)       state_d = ST_DN;
                else                   state_d = ST_IDLE;
            end
            ST_UP:   if (fb_stb)  state_d = ST_CLR;
            ST_DN:   if (ref_stb) state_d = ST_CLR;
            default: state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/pfd_out_enc.sv
module pfd_out_enc
    import pfd_pkg::*;
(
    input  pfd_state_e state,
    output logic       err_drive,
    output logic       err_oe,
    output logic       pump_up_n,
    output logic       pump_dn_n
);

    always_comb begin
        err_drive = 1'b0;
        err_oe    = 1'b0;
        pump_up_n = 1'b1;
        pump_dn_n = 1'b1;
        unique case (state)
            ST_IDLE: ;
            ST_UP: begin
                err_drive = 1'b1;
                err_oe    = 1'b1;
                pump_up_n = 1'b0;
            end
            ST_DN: begin
                err_oe    = 1'b1;
                pump_dn_n = 1'b0;
            end
            ST_CLR: begin
                pump_up_n = 1'b0;
                pump_dn_n = 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon
    import pfd_pkg::*;
#(
    parameter int LOCK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pfd_state_e        state,
    input  logic [LOCK_W-1:0] lock_thresh,
    output logic              locked
);

    localparam logic [LOCK_W-1:0] CNT_MAX = {LOCK_W{1'b1}};

    logic              one_sided;
    logic              held_q;
    logic              wide_now;
    logic              wide_q;
    logic [LOCK_W-1:0] good_q;

    assign one_sided = (state == ST_UP) || (state == ST_DN);
    assign wide_now  = one_sided && held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= 1'b0;
            wide_q <= 1'b0;
            good_q <= '0;
        end else begin
            held_q <= one_sided;
            if (wide_now) begin
                wide_q <= 1'b1;
                good_q <= '0;
            end else if (state == ST_CLR) begin
                wide_q <= 1'b0;
                if (!wide_q && good_q != CNT_MAX) good_q <= good_q + 1'b1;
            end
        end
    end

    assign locked = (good_q != '0) && (good_q >= lock_thresh);

endmodule

// File: rtl/pfd_tristate.sv
module pfd_tristate
    import pfd_pkg::*;
#(
    parameter int LOCK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_stb,
    input  logic              fb_stb,
    input  logic [LOCK_W-1:0] lock_thresh,
    output logic              err_drive,
    output logic              err_oe,
    output logic              pump_up_n,
    output logic              pump_dn_n,
    output logic              locked
);

    pfd_state_e state;

    pfd_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_stb (ref_stb),
        .fb_stb  (fb_stb),
        .state_q (state)
    );

    pfd_out_enc u_enc (
        .state     (state),
        .err_drive (err_drive),
        .err_oe    (err_oe),
        .pump_up_n (pump_up_n),
        .pump_dn_n (pump_dn_n)
    );

    pfd_lock_mon #(.LOCK_W(LOCK_W)) u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (state),
        .lock_thresh (lock_thresh),
        .locked      (locked)
    );

endmodule

// File: rtl/pfd_tristate_chk.sv
module pfd_tristate_chk (
    input logic clk,
    input logic rst_n,
    input logic ref_stb,
    input logic fb_stb,
    input logic err_drive,
    input logic err_oe,
    input logic pump_up_n,
    input logic pump_dn_n,
    input logic locked
);

    // R2 R3: an enabled error output matches exactly one active pump
    p_oe_one_pump_r2: assert property (@(posedge clk) disable iff (!rst_n)
        err_oe |-> (pump_up_n != pump_dn_n));

    // R2: drive high only alongside the up pump
    p_drive_high_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (err_oe && err_drive) |-> (!pump_up_n && pump_dn_n));

    // R4: the clear cycle ends after one cycle unless both strobes land in it
    p_clear_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pump_up_n && !pump_dn_n && !(ref_stb && fb_stb)) |=> !(!pump_up_n && !pump_dn_n));

    // R4 R5: both pumps active means high impedance
    p_clear_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pump_up_n && !pump_dn_n) |-> !err_oe);

    // R7: a pending up pulse holds until a feedback strobe
    p_up_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pump_up_n && pump_dn_n && !fb_stb) |=> (!pump_up_n && pump_dn_n));

    // R10: an up pulse in its second cycle drops lock next cycle
    p_wide_drops_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!pump_up_n && pump_dn_n && $past(!pump_up_n && pump_dn_n)) |=> !locked);

endmodule

bind pfd_tristate pfd_tristate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_stb   (ref_stb),
    .fb_stb    (fb_stb),
    .err_drive (err_drive),
    .err_oe    (err_oe),
    .pump_up_n (pump_up_n),
    .pump_dn_n (pump_dn_n),
    .locked    (locked)
);

// File: tb/tb_pfd_tristate.sv
`timescale 1ns/1ps
module tb_pfd_tristate;

    localparam int LW = 8;
    localparam int GMAX = (1 << LW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_stb = 1'b0;
    logic          fb_stb = 1'b0;
    logic [LW-1:0] lock_thresh = 8'd3;
    logic          err_drive, err_oe, pump_up_n, pump_dn_n, locked;

    int total = 0;
    int bad = 0;
    int hi_cnt = 0;
    int lo_cnt = 0;

    // behavioural reference: two pending flags and lock bookkeeping
    bit m_up, m_dn, m_wide;
    int m_run, m_good;

    always #2 clk = ~clk;

    pfd_tristate #(.LOCK_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .fb_stb(fb_stb),
        .lock_thresh(lock_thresh), .err_drive(err_drive), .err_oe(err_oe),
        .pump_up_n(pump_up_n), .pump_dn_n(pump_dn_n), .locked(locked)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_up = 0; m_dn = 0; m_wide = 0; m_run = 0; m_good = 0;
        end else begin
            if (m_up != m_dn) begin
                if (m_run >= 1) begin m_good = 0; m_wide = 1; end
                m_run++;
            end else begin
                m_run = 0;
                if (m_up && m_dn) begin
                    if (!m_wide && m_good < GMAX) m_good++;
                    m_wide = 0;
                end
            end
            if (m_up && m_dn) begin m_up = 0; m_dn = 0; end
            if (ref_stb) m_up = 1;
            if (fb_stb)  m_dn = 1;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        chk("R2/R3", "err_oe", int'(err_oe), int'(m_up != m_dn));
        if (m_up != m_dn) chk("R2/R3", "err_drive", int'(err_drive), int'(m_up));
        chk("R6", "pump_up_n", int'(pump_up_n), int'(!m_up));
        chk("R6", "pump_dn_n", int'(pump_dn_n), int'(!m_dn));
        chk("R9/R10", "locked", int'(locked),
            int'(m_good != 0 && m_good >= int'(lock_thresh)));
        if (err_oe && err_drive)  hi_cnt++;
        if (err_oe && !err_drive) lo_cnt++;
    end

    task automatic tick(input bit r, input bit f);
        @(negedge clk);
        ref_stb = r;
        fb_stb  = f;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0);
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    task automatic zero_counts();
        @(posedge clk);
        hi_cnt = 0;
        lo_cnt = 0;
    endtask

    initial begin
        #200000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "reset err_oe", int'(err_oe), 0);
        chk("R1", "reset pump_up_n", int'(pump_up_n), 1);
        chk("R1", "reset pump_dn_n", int'(pump_dn_n), 1);
        chk("R1", "reset locked", int'(locked), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R5: coincident strobes, three times to reach lock
        tick(1, 1);
        settle();
        chk("R5", "coincident both pumps low", int'(pump_up_n | pump_dn_n), 0);
        chk("R5", "coincident hi-Z", int'(err_oe), 0);
        idle(2);
        tick(1, 1); idle(2);
        tick(1, 1); idle(2);
        settle();
        chk("R9", "locked after threshold", int'(locked), 1);

        // R10: one-cycle lead does not break lock
        tick(1, 0); tick(0, 1); idle(2);
        settle();
        chk("R10", "one-cycle lead keeps lock", int'(locked), 1);

        // R2 and R6: reference leads by 3 cycles
        zero_counts();
        tick(1, 0); idle(2); tick(0, 1); idle(3);
        settle();
        chk("R6", "drive-high width", hi_cnt, 3);
        chk("R10", "wide pulse drops lock", int'(locked), 0);

        // R3: feedback leads by 4 cycles
        zero_counts();
        tick(0, 1); idle(3);
        settle();
        chk("R3", "drive low polarity", int'(err_drive), 0);
        tick(1, 0);
        settle();
        chk("R4", "clear both pumps low", int'(pump_up_n | pump_dn_n), 0);
        chk("R4", "clear hi-Z", int'(err_oe), 0);
        idle(3);
        settle();
        chk("R3", "drive-low width", lo_cnt, 4);

        // R7: repeated reference strobes while up is pending
        zero_counts();
        tick(1, 0); tick(1, 0); tick(1, 0); tick(0, 1); idle(3);
        settle();
        chk("R7", "repeat strobe ignored width", hi_cnt, 3);
        chk("R7", "no drive-low from repeats", lo_cnt, 0);

        // R8: feedback strobe during the clear cycle starts a new comparison
        tick(1, 0); tick(0, 1); tick(0, 1);
        settle();
        chk("R8", "new DN after clear oe", int'(err_oe), 1);
        chk("R8", "new DN after clear drive", int'(err_drive), 0);
        tick(1, 0); idle(3);

        // R9: lower threshold to 1, one clean comparison relocks
        lock_thresh = 8'd1;
        tick(1, 1); idle(2);
        settle();
        chk("R9", "relock at threshold 1", int'(locked), 1);

        // R9: threshold above count keeps lock low
        lock_thresh = 8'd200;
        idle(1);
        settle();
        chk("R9", "threshold above count", int'(locked), 0);
        lock_thresh = 8'd3;

        idle(4);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule